// File: doc/BRIEF.md
# Short Branch and Predicate Flag Unit

This block executes the compact 16-bit conditional-branch group. Any instruction whose top four bits are `0111` belongs to the group. Its operation nibble, bits 11..8, selects one of two things. The first is a conditional branch, tested against the carry, overflow and zero condition codes. The second is an operation on one of sixteen single-bit predicate flags. A branch that is taken produces a target slot address. That address is found by adding a signed 8-bit displacement, counted in 32-bit slots, to the slot that follows the one holding the instruction.

The caller presents one instruction per cycle, qualified by `instr_valid`, together with the slot address it was fetched from and the current condition codes. One clock later the unit reports `taken` and `target`, and the predicate flags show any change. The position of the instruction within its slot makes no difference. The offset is always taken from the next slot, and slots that hold header information are counted like any other. A separate write port lets surrounding logic load any predicate flag directly.

Top module: `short_branch_unit`

## Requirements
- R1: While `rst_n` is low, and on the first cycle after it rises, `taken` is 0, `target` is 0 and all sixteen flags are 0.
- R2: For a valid group instruction, the nibble in bits 11..8 selects a branch as follows: 0001 branches on carry (low); 0010 on zero (equal); 0011 on carry or zero; 0100 when neither carry nor zero is set (high); 0101 when zero is clear; 0110 when carry is clear; 0111 when overflow is clear; 1000 when overflow is set; 1010 on carry; 1011 when carry is clear; 1111 always. `taken` goes high in the following cycle exactly when the condition is met.
- R3: When a branch is taken, `target` in the following cycle equals `slot_addr + 1 + sext(instr[7:0])` modulo 2^ADDR_W. The value of `second_half` has no effect on it.
- R4: The displacement covers the full range -128 to +127 and wraps across address 0 and across the top of the address space.
- R5: When `instr_valid` is low, or bits 15..12 are not `0111`, `taken` stays 0 and no flag changes, except through the write port.
- R6: Nibble 0000 is a flag copy. The flag selected by bits 7..4 takes the value 1 if the condition encoded in bits 3..0 is met, and 0 if it is not. The condition uses the same encoding as R2.
- R7: Nibble 1100 sets the selected flag to 1 when the condition in bits 3..0 is met, and leaves it unchanged otherwise.
- R8: Nibble 1101 clears the selected flag to 0 when the condition in bits 3..0 is met, and leaves it unchanged otherwise.
- R9: Nibbles 1001 and 1110 do nothing: no branch is taken and no flag changes. A flag operation never raises `taken`.
- R10: In a flag operation, a condition nibble that is not a branch code (0000, 1001, 1100, 1101 or 1110) counts as not met.
- R11: When `flag_wr_en` is high, flag `flag_wr_idx` takes the value `flag_wr_data` at the clock edge. If an instruction addresses the same flag in the same cycle, the write port wins.
- R12: `target` changes only when a branch is taken. In all other cycles it keeps its last value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| instr_valid | input | 1 | Qualifies `instr` this cycle |
| instr | input | 16 | Compact instruction word |
| slot_addr | input | ADDR_W | Address of the 32-bit slot holding the instruction |
| second_half | input | 1 | Instruction sits in the upper half of its slot (no effect on target) |
| cc_c | input | 1 | Carry condition code |
| cc_v | input | 1 | Overflow condition code |
| cc_z | input | 1 | Zero condition code |
| cc_n | input | 1 | Negative condition code (not used by the unsigned compares) |
| flag_wr_en | input | 1 | Direct flag write enable |
| flag_wr_idx | input | 4 | Flag index for the direct write |
| flag_wr_data | input | 1 | Value for the direct write |
| taken | output | 1 | Branch taken, one cycle after the instruction |
| target | output | ADDR_W | Target slot address of the last taken branch |
| flags | output | 16 | Predicate flag register |

## Verification
A wrong condition decode shows up on `taken` in the cycle after the instruction. A wrong displacement extension shows up on `target` in that same cycle, but only for taken branches. Flag errors are more persistent. A wrong index or kind leaves a bad flag value that stays on `flags` until a later operation rewrites it. For that reason the reference model compares the whole flag vector on every clock, not only after flag instructions, so a corrupted state is caught in the cycle it appears and cannot be masked later.

// File: rtl/sbr_pkg.sv
package sbr_pkg;

   localparam int          INSTR_W    = 16;
   localparam int          DISP_W     = 8;
   localparam int          FLAG_IDX_W = 4;
   localparam logic [3:0]  GROUP_TAG  = 4'b0111;

   typedef enum logic [3:0] {
      OPC_FLAG_COPY = 4'h0,
      OPC_LOW       = 4'h1,
      OPC_EQ        = 4'h2,
      OPC_LOW_EQ    = 4'h3,
      OPC_HIGH      = 4'h4,
      OPC_NE        = 4'h5,
      OPC_HIGH_EQ   = 4'h6,
      OPC_NO_OVF    = 4'h7,
      OPC_OVF       = 4'h8,
      OPC_RSV_A     = 4'h9,
      OPC_CARRY     = 4'hA,
      OPC_NO_CARRY  = 4'hB,
      OPC_FLAG_SET  = 4'hC,
      OPC_FLAG_CLR  = 4'hD,
      OPC_RSV_B     = 4'hE,
      OPC_ALWAYS    = 4'hF
   } opc_e;

   typedef enum logic [1:0] {
      ACT_NONE   = 2'd0,
      ACT_BRANCH = 2'd1,
      ACT_FLAG   = 2'd2
   } act_e;

   typedef enum logic [1:0] {
      FOP_COPY = 2'd0,
      FOP_SET  = 2'd1,
      FOP_CLR  = 2'd2
   } fop_e;

   typedef struct packed {
      act_e                  act;
      fop_e                  fop;
      logic [3:0]            bcond;
      logic [FLAG_IDX_W-1:0] fidx;
      logic [3:0]            fcond;
      logic [DISP_W-1:0]     disp;
   } dec_t;

endpackage

// File: rtl/sbr_cond_eval.sv
module sbr_cond_eval
   import sbr_pkg::*;
(
   input  logic [3:0] code,
   input  logic       cc_c,
   input  logic       cc_v,
   input  logic       cc_z,
   output logic       is_cond,
   output logic       met
);

   always_comb begin
      is_cond = 1'b1;
      met     = 1'b0;
      unique case (opc_e'(code))
         OPC_LOW:      met = cc_c;
         OPC_EQ:       met = cc_z;
         OPC_LOW_EQ:   met = cc_c | cc_z;
         OPC_HIGH:     met = ~cc_c & ~cc_z;
         OPC_NE:       met = ~cc_z;
         OPC_HIGH_EQ:  met = ~cc_c;
         OPC_NO_OVF:   met = ~cc_v;
         OPC_OVF:      met = cc_v;
         OPC_CARRY:    met = cc_c;
         OPC_NO_CARRY: met = ~cc_c;
         OPC_ALWAYS:   met = 1'b1;
         default: begin
            is_cond = 1'b0;
            met     = 1'b0;
         end
      endcase
   end

endmodule

// File: rtl/sbr_decode.sv
module sbr_decode
   import sbr_pkg::*;
(
   input  logic               valid,
   input  logic [INSTR_W-1:0] instr,
   output dec_t               dec
);

   logic       in_group;
   logic [3:0] opc;

   assign in_group = valid && (instr[15:12] == GROUP_TAG);
   assign opc      = instr[11:8];

   always_comb begin
      dec.act   = ACT_NONE;
      dec.fop   = FOP_COPY;
      dec.bcond = opc;
      dec.fidx  = instr[7:4];
      dec.fcond = instr[3:0];
      dec.disp  = instr[DISP_W-1:0];
      if (in_group) begin
         unique case (opc_e'(opc))
            OPC_FLAG_COPY: begin dec.act = ACT_FLAG; dec.fop = FOP_COPY; end
            OPC_FLAG_SET:  begin dec.act = ACT_FLAG; dec.fop = FOP_SET;  end
            OPC_FLAG_CLR:  begin dec.act = ACT_FLAG; dec.fop = FOP_CLR;  end
            OPC_RSV_A,
            OPC_RSV_B:     dec.act = ACT_NONE;
            default:       dec.act = ACT_BRANCH;
         endcase
      end
   end

endmodule

// File: rtl/sbr_target.sv
module sbr_target
   import sbr_pkg::*;
#(
   parameter int ADDR_W = 16
) (
   input  logic [ADDR_W-1:0] slot_addr,
   input  logic              half,
   input  logic [DISP_W-1:0] disp,
   output logic [ADDR_W-1:0] target
);

   localparam int EXT_W = ADDR_W - DISP_W;

   generate
      if (ADDR_W <= DISP_W) begin : g_bad_width
         $error("sbr_target: ADDR_W must exceed the displacement width");
      end
   endgenerate

   logic [ADDR_W-1:0] next_slot;
   logic [ADDR_W-1:0] disp_ext;
   logic              half_unused;

   // Offset is always taken from the following slot; the half bit plays no role.
   assign half_unused = half;
   assign next_slot   = slot_addr + ADDR_W'(1);
   assign disp_ext    = {{EXT_W{disp[DISP_W-1]}}, disp};
   assign target      = next_slot + disp_ext;

endmodule

// File: rtl/sbr_flag_file.sv
module sbr_flag_file
   import sbr_pkg::*;
#(
   parameter int NUM_FLAGS = 16
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  op_en,
   input  fop_e                  op_kind,
   input  logic [FLAG_IDX_W-1:0] op_idx,
   input  logic                  op_met,
   input  logic                  wr_en,
   input  logic [FLAG_IDX_W-1:0] wr_idx,
   input  logic                  wr_data,
   output logic [NUM_FLAGS-1:0]  flags
);

   generate
      if (NUM_FLAGS != (1 << FLAG_IDX_W)) begin : g_bad_count
         $error("sbr_flag_file: NUM_FLAGS must match the index field");
      end
   endgenerate

   genvar gi;
   generate
      for (gi = 0; gi < NUM_FLAGS; gi++) begin : g_flag
         logic hit_wr;
         logic hit_op;
         logic nxt;

         assign hit_wr = wr_en && (wr_idx == FLAG_IDX_W'(gi));
         assign hit_op = op_en && (op_idx == FLAG_IDX_W'(gi));

         always_comb begin
            nxt = flags[gi];
            if (hit_wr) begin
               nxt = wr_data;
            end else if (hit_op) begin
               unique case (op_kind)
                  FOP_COPY: nxt = op_met;
                  FOP_SET:  if (op_met) nxt = 1'b1;
                  FOP_CLR:  if (op_met) nxt = 1'b0;
                  default:  nxt = flags[gi];
               endcase
            end
         end

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) flags[gi] <= 1'b0;
            else        flags[gi] <= nxt;
         end
      end
   endgenerate

endmodule

// File: rtl/short_branch_unit.sv
module short_branch_unit
   import sbr_pkg::*;
#(
   parameter int ADDR_W    = 16,
   parameter int NUM_FLAGS = 16
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  instr_valid,
   input  logic [15:0]           instr,
   input  logic [ADDR_W-1:0]     slot_addr,
   input  logic                  second_half,
   input  logic                  cc_c,
   input  logic                  cc_v,
   input  logic                  cc_z,
   input  logic                  cc_n,
   input  logic                  flag_wr_en,
   input  logic [3:0]            flag_wr_idx,
   input  logic                  flag_wr_data,
   output logic                  taken,
   output logic [ADDR_W-1:0]     target,
   output logic [NUM_FLAGS-1:0]  flags
);

   dec_t              dec;
   logic              br_is_cond, br_met;
   logic              fl_is_cond, fl_met;
   logic [ADDR_W-1:0] tgt_calc;
   logic              take_nxt;
   logic              cc_n_unused;

   // Compares are unsigned; the sign code is accepted but not consulted.
   assign cc_n_unused = cc_n;

   sbr_decode u_dec (
      .valid (instr_valid),
      .instr (instr),
      .dec   (dec)
   );

   sbr_cond_eval u_br_cond (
      .code    (dec.bcond),
      .cc_c    (cc_c),
      .cc_v    (cc_v),
      .cc_z    (cc_z),
      .is_cond (br_is_cond),
      .met     (br_met)
   );

   sbr_cond_eval u_fl_cond (
      .code    (dec.fcond),
      .cc_c    (cc_c),
      .cc_v    (cc_v),
      .cc_z    (cc_z),
      .is_cond (fl_is_cond),
      .met     (fl_met)
   );

   sbr_target #(.ADDR_W(ADDR_W)) u_tgt (
      .slot_addr (slot_addr),
      .half      (second_half),
      .disp      (dec.disp),
      .target    (tgt_calc)
   );

   sbr_flag_file #(.NUM_FLAGS(NUM_FLAGS)) u_flags (
      .clk     (clk),
      .rst_n   (rst_n),
      .op_en   (dec.act == ACT_FLAG),
      .op_kind (dec.fop),
      .op_idx  (dec.fidx),
      .op_met  (fl_is_cond & fl_met),
      .wr_en   (flag_wr_en),
      .wr_idx  (flag_wr_idx),
      .wr_data (flag_wr_data),
      .flags   (flags)
   );

   assign take_nxt = (dec.act == ACT_BRANCH) && br_is_cond && br_met;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         taken  <= 1'b0;
         target <= '0;
      end else begin
         taken <= take_nxt;
         if (take_nxt) target <= tgt_calc;
      end
   end

endmodule

// File: rtl/sbr_checker.sv
module sbr_checker #(
   parameter int ADDR_W    = 16,
   parameter int NUM_FLAGS = 16
) (
   input logic                 clk,
   input logic                 rst_n,
   input logic                 instr_valid,
   input logic [15:0]          instr,
   input logic                 flag_wr_en,
   input logic                 taken,
   input logic [ADDR_W-1:0]    target,
   input logic [NUM_FLAGS-1:0] flags
);

   logic armed;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) armed <= 1'b0;
      else        armed <= 1'b1;
   end

   logic       grp;
   logic [3:0] opn;
   assign grp = instr_valid && (instr[15:12] == 4'b0111);
   assign opn = instr[11:8];

   assert_reset_clear_R1: assert property (@(posedge clk)
      !rst_n |=> (!taken && target == '0 && flags == '0));

   assert_taken_source_R2: assert property (@(posedge clk) disable iff (!rst_n || !armed)
      taken |-> $past(grp));

   assert_quiet_R5: assert property (@(posedge clk) disable iff (!rst_n || !armed)
      (!grp && !flag_wr_en) |=> ($stable(flags) && !taken));

   assert_copy_one_flag_R6: assert property (@(posedge clk) disable iff (!rst_n || !armed)
      (grp && opn == 4'h0 && !flag_wr_en) |=> ($countones(flags ^ $past(flags)) <= 1));

   assert_set_only_R7: assert property (@(posedge clk) disable iff (!rst_n || !armed)
      (grp && opn == 4'hC && !flag_wr_en) |=> (($past(flags) & ~flags) == '0));

   assert_clear_only_R8: assert property (@(posedge clk) disable iff (!rst_n || !armed)
      (grp && opn == 4'hD && !flag_wr_en) |=> ((~$past(flags) & flags) == '0));

   assert_reserved_R9: assert property (@(posedge clk) disable iff (!rst_n || !armed)
      (grp && (opn == 4'h9 || opn == 4'hE) && !flag_wr_en) |=> (!taken && $stable(flags)));

   assert_target_hold_R12: assert property (@(posedge clk) disable iff (!rst_n || !armed)
      !taken |-> $stable(target));

endmodule

bind short_branch_unit sbr_checker #(.ADDR_W(ADDR_W), .NUM_FLAGS(NUM_FLAGS)) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .instr_valid (instr_valid),
   .instr       (instr),
   .flag_wr_en  (flag_wr_en),
   .taken       (taken),
   .target      (target),
   .flags       (flags)
);

// File: tb/short_branch_unit_test.sv
module short_branch_unit_test;

   localparam int AW = 16;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          instr_valid = 1'b0;
   logic [15:0]   instr = '0;
   logic [AW-1:0] slot_addr = '0;
   logic          second_half = 1'b0;
   logic          cc_c = 1'b0, cc_v = 1'b0, cc_z = 1'b0, cc_n = 1'b0;
   logic          flag_wr_en = 1'b0;
   logic [3:0]    flag_wr_idx = '0;
   logic          flag_wr_data = 1'b0;
   logic          taken;
   logic [AW-1:0] target;
   logic [15:0]   flags;

   int checks = 0;
   int fails  = 0;

   // reference state
   logic          m_taken = 1'b0;
   logic [AW-1:0] m_target = '0;
   logic [15:0]   m_flags = '0;

   always #10 clk = ~clk;   // 50 MHz

   short_branch_unit #(.ADDR_W(AW), .NUM_FLAGS(16)) uut (
      .clk(clk), .rst_n(rst_n), .instr_valid(instr_valid), .instr(instr),
      .slot_addr(slot_addr), .second_half(second_half),
      .cc_c(cc_c), .cc_v(cc_v), .cc_z(cc_z), .cc_n(cc_n),
      .flag_wr_en(flag_wr_en), .flag_wr_idx(flag_wr_idx), .flag_wr_data(flag_wr_data),
      .taken(taken), .target(target), .flags(flags)
   );

   function automatic bit cond_ok(input logic [3:0] code, input bit c, input bit v, input bit z);
      case (code)
         4'h1: return c;
         4'h2: return z;
         4'h3: return c || z;
         4'h4: return !c && !z;
         4'h5: return !z;
         4'h6: return !c;
         4'h7: return !v;
         4'h8: return v;
         4'hA: return c;
         4'hB: return !c;
         4'hF: return 1'b1;
         default: return 1'b0;
      endcase
   endfunction

   task automatic compare(input string tag);
      checks++;
      if (taken !== m_taken) begin
         fails++;
         $display("FAIL %s taken actual=%0b expected=%0b", tag, taken, m_taken);
      end
      checks++;
      if (target !== m_target) begin
         fails++;
         $display("FAIL %s target actual=%h expected=%h", tag, target, m_target);
      end
      checks++;
      if (flags !== m_flags) begin
         fails++;
         $display("FAIL %s flags actual=%h expected=%h", tag, flags, m_flags);
      end
   endtask

   // Drive at a falling edge, update the model at the rising edge, compare at the next falling edge.
   task automatic step(input bit v, input logic [15:0] ins, input logic [AW-1:0] slot,
                       input bit hf, input logic [2:0] cvz, input bit we,
                       input logic [3:0] wi, input bit wd, input string tag);
      logic [3:0] opn;
      logic [3:0] fi;
      bit         fm;
      instr_valid  = v;   instr = ins;   slot_addr = slot;  second_half = hf;
      cc_c = cvz[2];      cc_v = cvz[1]; cc_z = cvz[0];     cc_n = $urandom_range(0, 1);
      flag_wr_en   = we;  flag_wr_idx = wi; flag_wr_data = wd;
      @(posedge clk);
      m_taken = 1'b0;
      opn = ins[11:8];
      fi  = ins[7:4];
      fm  = cond_ok(ins[3:0], cvz[2], cvz[1], cvz[0]);
      if (v && ins[15:12] == 4'b0111) begin
         if (opn == 4'h0)      m_flags[fi] = fm;
         else if (opn == 4'hC) begin if (fm) m_flags[fi] = 1'b1; end
         else if (opn == 4'hD) begin if (fm) m_flags[fi] = 1'b0; end
         else if (cond_ok(opn, cvz[2], cvz[1], cvz[0])) begin
            m_taken  = 1'b1;
            m_target = AW'(int'(slot) + 1 + int'($signed(ins[7:0])));
         end
      end
      if (we) m_flags[wi] = wd;
      @(negedge clk);
      compare(tag);
   endtask

   task automatic idle(input string tag);
      step(0, 16'h0000, '0, 0, 3'b000, 0, 4'h0, 0, tag);
   endtask

   initial begin : watchdog
      #(200000 * 20);
      checks++;
      fails++;
      $display("FAIL R1 watchdog actual=running expected=finished");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end

   initial begin : main
      repeat (3) @(negedge clk);
      compare("R1 in reset");
      rst_n = 1'b1;
      @(negedge clk);
      compare("R1 after reset");

      // R2, R6..R10: every operation nibble against every carry/overflow/zero combination
      for (int op = 0; op < 16; op++) begin
         for (int cc = 0; cc < 8; cc++) begin
            step(1, {4'b0111, 4'(op), 4'(op + cc), 4'((op * 3 + cc) % 16)},
                 AW'(16'h0200 + op * 8 + cc), cc[0], 3'(cc), 0, 4'h0, 0,
                 "R2/R6/R7/R8/R9/R10 sweep");
         end
      end

      // R3: the half bit does not move the target
      step(1, 16'h7F00, 16'd100, 0, 3'b000, 0, 4'h0, 0, "R3 first half disp 0");
      step(1, 16'h7F00, 16'd100, 1, 3'b000, 0, 4'h0, 0, "R3 second half disp 0");
      step(1, 16'h7F05, 16'd100, 1, 3'b000, 0, 4'h0, 0, "R3 second half disp 5");

      // R4: range ends and wrap
      step(1, 16'h7F7F, 16'd1000, 0, 3'b000, 0, 4'h0, 0, "R4 disp +127");
      step(1, 16'h7F80, 16'd1000, 0, 3'b000, 0, 4'h0, 0, "R4 disp -128");
      step(1, 16'h7F00, 16'hFFFF, 0, 3'b000, 0, 4'h0, 0, "R4 wrap top");
      step(1, 16'h7F80, 16'h0005, 0, 3'b000, 0, 4'h0, 0, "R4 wrap below zero");
      step(1, 16'h7FFF, 16'h0000, 0, 3'b000, 0, 4'h0, 0, "R4 disp -1 at zero");

      // R12: untaken branch leaves target alone
      step(1, 16'h7112, 16'h4444, 0, 3'b000, 0, 4'h0, 0, "R12 untaken low");
      idle("R12 idle hold");

      // R5: invalid strobe and foreign groups
      step(0, 16'h7F10, 16'h0123, 0, 3'b111, 0, 4'h0, 0, "R5 valid low");
      step(1, 16'h6F10, 16'h0123, 0, 3'b111, 0, 4'h0, 0, "R5 other group");
      step(0, 16'h0C3F, 16'h0123, 0, 3'b111, 0, 4'h0, 0, "R5 valid low flag op");
      step(1, 16'hFC3F, 16'h0123, 0, 3'b111, 0, 4'h0, 0, "R5 other group flag op");

      // R7/R8: set and clear on flag 3, met and not met
      step(1, 16'h7C3F, '0, 0, 3'b000, 0, 4'h0, 0, "R7 set met");
      step(1, 16'h7D31, '0, 0, 3'b000, 0, 4'h0, 0, "R8 clear not met");
      step(1, 16'h7D31, '0, 0, 3'b100, 0, 4'h0, 0, "R8 clear met");
      step(1, 16'h7C31, '0, 0, 3'b000, 0, 4'h0, 0, "R7 set not met");

      // R9: reserved nibbles with conditions that would be met
      step(1, 16'h79FF, '0, 0, 3'b111, 0, 4'h0, 0, "R9 reserved 1001");
      step(1, 16'h7E5F, '0, 0, 3'b111, 0, 4'h0, 0, "R9 reserved 1110");

      // R10: invalid condition nibble in a flag copy writes 0
      step(1, 16'h7C9F, '0, 0, 3'b000, 0, 4'h0, 0, "R10 prep set flag 9");
      step(1, 16'h709E, '0, 0, 3'b111, 0, 4'h0, 0, "R10 copy invalid cond");

      // R11: write port alone, then against an instruction on the same flag
      step(0, 16'h0000, '0, 0, 3'b000, 1, 4'hA, 1, "R11 direct write");
      step(1, 16'h70AF, '0, 0, 3'b000, 1, 4'hA, 0, "R11 port beats copy");
      step(1, 16'h7C2F, '0, 0, 3'b000, 1, 4'hB, 1, "R11 separate flags");

      // mixed random traffic
      for (int k = 0; k < 3000; k++) begin
         step($urandom_range(0, 7) != 0,
              ($urandom_range(0, 3) != 0) ? {4'b0111, 12'($urandom)} : 16'($urandom),
              AW'($urandom), $urandom_range(0, 1), 3'($urandom),
              $urandom_range(0, 5) == 0, 4'($urandom), $urandom_range(0, 1),
              "R2/R3/R6/R11/R12 random");
      end

      // R1 again: reset mid-run clears everything
      rst_n = 1'b0;
      m_taken = 1'b0; m_target = '0; m_flags = '0;
      @(negedge clk);
      compare("R1 re-reset");
      rst_n = 1'b1;

      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end

endmodule